// File: doc/BRIEF.md
# Peripheral-channel completion responder

This block sits next to an eSPI slave controller and acts as a memory-mapped bus master on the controller's register interface. It answers one-byte memory read requests that the host has placed in one of two receive FIFO registers. One pair of receive and transmit FIFO registers serves the peripheral channel and the other serves non-posted traffic. When a channel reports a pending request, the block reads that channel's receive FIFO until the FIFO reports empty. While it reads, it collects the 32-bit request address from the header bytes.

The block then presents the address on a lookup port and receives either a data byte or an error indication. Next it waits until the channel's transmit FIFO is free, because that FIFO holds only one packet. It writes the completion packet into the transmit FIFO one byte per bus write, header first and data last. A final write to the shared control register commits the packet, using the trigger bit of that channel. A busy flag covers the whole exchange, and a one-cycle done pulse marks the commit.

Top module: `rsp_pc_responder`

## Requirements
- R1: While reset is held and in the first cycle after it is released, with no request pending, `busy`, `done`, `avm_read`, `avm_write` and `lk_valid` are all low.
- R2: A bus read or write keeps its request, address and write data steady while `avm_waitrequest` is high. Read data is taken only in a cycle with `avm_readdatavalid` high. A read and a write are never requested in the same cycle.
- R3: Receive reads go to offset 0x08 for the peripheral channel and to offset 0x10 for the non-posted channel. Reads repeat until a returned word has bit 8 set, which means empty. Otherwise bits 7:0 carry the next byte.
- R4: The request address is built from the bytes at positions 3, 4, 5 and 6 of the drained stream, counting from 0, most significant byte first. Any bytes after position 6 are read and discarded.
- R5: `lk_valid` stays high with `lk_addr` unchanged until `lk_ready` is high. `lk_data` and `lk_err` are sampled in that same cycle.
- R6: On a successful lookup, the channel's transmit FIFO receives 0x0F, then 0x00, then 0x01, then the looked-up byte, each in bits 7:0 of the write data. The transmit FIFO is at offset 0x0C for the peripheral channel and 0x14 for the non-posted channel.
- R7: On a lookup error, the transmit FIFO receives 0x0C, then 0x00, then 0x00, with no data byte.
- R8: After the last packet byte, exactly one write goes to offset 0x04. Its value is 0x01 for the peripheral channel and 0x02 for the non-posted channel.
- R9: No transmit FIFO write is made to a channel while that channel's `*_tx_free` input is low.
- R10: `busy` is high from the first receive read until the commit write is accepted. In the next cycle `busy` is low and `done` is high for exactly one cycle.
- R11: When both channels request in the same cycle, the peripheral channel is served completely first.
- R12: If the FIFO reports empty before position 6 has been read, the block performs no lookup, no transmit write and no commit, gives no done pulse, and returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pc_req | input | 1 | Peripheral-channel receive FIFO holds a request |
| np_req | input | 1 | Non-posted receive FIFO holds a request |
| pc_tx_free | input | 1 | Peripheral-channel transmit FIFO can take a packet |
| np_tx_free | input | 1 | Non-posted transmit FIFO can take a packet |
| avm_address | output | 8 | Register offset |
| avm_read | output | 1 | Read request |
| avm_write | output | 1 | Write request |
| avm_writedata | output | 32 | Write data, byte in bits 7:0 |
| avm_readdata | input | 32 | Read data, byte in 7:0, empty flag in bit 8 |
| avm_readdatavalid | input | 1 | Read data valid |
| avm_waitrequest | input | 1 | Slave stall |
| lk_valid | output | 1 | Lookup request |
| lk_addr | output | 32 | Lookup address |
| lk_ready | input | 1 | Lookup answer present |
| lk_data | input | 8 | Lookup data byte |
| lk_err | input | 1 | Lookup failed |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle pulse after commit |

## Verification
Several request patterns are applied, and each one separates a different possible fault. A clean peripheral request with no stalls checks the packet order and the commit value. A non-posted request under random wait states and read latency shows whether offsets are taken from the correct channel and whether data is sampled only on a valid beat. An error address and a request with trailing bytes separate the failure packet from the success packet and show whether the address is taken from the right byte window. Holding the transmit FIFO busy, raising both requests at once, and sending a truncated request test the gating, the channel priority and the abort path.

// File: rtl/rsp_pkg.sv
// Shared types of the completion responder.
// Assumes: nothing beyond IEEE 1800-2017.
package rsp_pkg;
    typedef enum logic [0:0] {CH_PC = 1'b0, CH_NP = 1'b1} chan_e;

    typedef enum logic [2:0] {
        S_IDLE, S_DRAIN, S_LOOKUP, S_TXWAIT, S_TXBYTE, S_COMMIT
    } seq_e;

    typedef enum logic [1:0] {B_IDLE, B_RD, B_RDWAIT, B_WR} bus_e;
endpackage

// File: rtl/rsp_bus_master.sv
// Single-outstanding memory-mapped master. It takes one command (read or
// write) in idle and holds it on the bus until waitrequest is low. For a
// read it then waits for readdatavalid.
// Assumes: read data arrives no earlier than the cycle after acceptance.
module rsp_bus_master import rsp_pkg::*; #(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          go_wr,
    input  logic [AW-1:0] go_addr,
    input  logic [DW-1:0] go_data,
    output logic          ack,
    output logic [DW-1:0] rdata,
    output logic [AW-1:0] avm_address,
    output logic          avm_read,
    output logic          avm_write,
    output logic [DW-1:0] avm_writedata,
    input  logic [DW-1:0] avm_readdata,
    input  logic          avm_readdatavalid,
    input  logic          avm_waitrequest
);
    bus_e          st;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;

    // Transaction state and latched command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= B_IDLE;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            case (st)
                B_IDLE: if (go) begin
                    addr_q <= go_addr;
                    data_q <= go_data;
                    st     <= go_wr ? B_WR : B_RD;
                end
                B_RD:     if (!avm_waitrequest) st <= B_RDWAIT;
                B_RDWAIT: if (avm_readdatavalid) st <= B_IDLE;
                B_WR:     if (!avm_waitrequest) st <= B_IDLE;
                default:  st <= B_IDLE;
            endcase
        end
    end

    // Bus drive and completion strobe.
    always_comb begin
        avm_read      = (st == B_RD);
        avm_write     = (st == B_WR);
        avm_address   = addr_q;
        avm_writedata = data_q;
        rdata         = avm_readdata;
        ack           = ((st == B_RDWAIT) && avm_readdatavalid) ||
                        ((st == B_WR) && !avm_waitrequest);
    end
endmodule

// File: rtl/rsp_pkt_gen.sv
// Produces the completion packet byte for a given position: cycle type,
// length high, length low, then the data byte on success only.
// Assumes: a one-byte data payload.
module rsp_pkt_gen #(
    parameter logic [7:0] CT_OK   = 8'h0F,
    parameter logic [7:0] CT_FAIL = 8'h0C
) (
    input  logic [1:0] idx,
    input  logic       err,
    input  logic [7:0] data,
    output logic [7:0] pkt_byte,
    output logic       last
);
    localparam logic [1:0] LAST_OK   = 2'd3;
    localparam logic [1:0] LAST_FAIL = 2'd2;

    // Byte selection per packet position.
    always_comb begin
        case (idx)
            2'd0:    pkt_byte = err ? CT_FAIL : CT_OK;
            2'd1:    pkt_byte = 8'h00;
            2'd2:    pkt_byte = err ? 8'h00 : 8'h01;
            default: pkt_byte = data;
        endcase
        last = (idx == (err ? LAST_FAIL : LAST_OK));
    end
endmodule

// File: rtl/rsp_addr_cap.sv
// Counts drained bytes and shifts the address window into a register,
// most significant byte first. Bytes outside the window are ignored.
// Assumes: ABYTES >= 2; clr is held while no request is in progress.
module rsp_addr_cap #(
    parameter int SKIP   = 3,
    parameter int ABYTES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  push,
    input  logic [7:0]            byte_in,
    output logic [8*ABYTES-1:0]   addr,
    output logic                  full
);
    localparam int            LA    = 8 * ABYTES;
    localparam int            LIMIT = SKIP + ABYTES;
    localparam int            CW    = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LO    = CW'(SKIP);
    localparam logic [CW-1:0] HI    = CW'(LIMIT);

    logic [CW-1:0] cnt;
    logic [LA-1:0] addr_q;

    // Byte counter and address shift register.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt    <= '0;
            addr_q <= '0;
        end else if (push) begin
            if (cnt >= LO && cnt < HI) addr_q <= {addr_q[LA-9:0], byte_in};
            if (cnt < HI) cnt <= cnt + 1'b1;
        end
    end

    assign addr = addr_q;
    assign full = (cnt == HI);
endmodule

// File: rtl/rsp_pc_responder.sv
// Completion responder. It drains a channel's receive FIFO, looks up the
// request address, writes a completion packet into the channel's transmit
// FIFO and commits it through the control register.
// Assumes: the *_req inputs are low once the receive FIFO is drained, and
// *_tx_free stays high while the block writes a packet.
module rsp_pc_responder import rsp_pkg::*; #(
    parameter int            AW         = 8,
    parameter int            DW         = 32,
    parameter int            ADDR_BYTES = 4,
    parameter int            HDR_SKIP   = 3,
    parameter int            EMPTY_BIT  = 8,
    parameter logic [AW-1:0] PC_RX_OFS  = 'h08,
    parameter logic [AW-1:0] PC_TX_OFS  = 'h0C,
    parameter logic [AW-1:0] NP_RX_OFS  = 'h10,
    parameter logic [AW-1:0] NP_TX_OFS  = 'h14,
    parameter logic [AW-1:0] CTL_OFS    = 'h04,
    parameter logic [7:0]    PC_AVAIL   = 8'h01,
    parameter logic [7:0]    NP_AVAIL   = 8'h02,
    parameter logic [7:0]    CT_OK      = 8'h0F,
    parameter logic [7:0]    CT_FAIL    = 8'h0C
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pc_req,
    input  logic                    np_req,
    input  logic                    pc_tx_free,
    input  logic                    np_tx_free,
    output logic [AW-1:0]           avm_address,
    output logic                    avm_read,
    output logic                    avm_write,
    output logic [DW-1:0]           avm_writedata,
    input  logic [DW-1:0]           avm_readdata,
    input  logic                    avm_readdatavalid,
    input  logic                    avm_waitrequest,
    output logic                    lk_valid,
    output logic [8*ADDR_BYTES-1:0] lk_addr,
    input  logic                    lk_ready,
    input  logic [7:0]              lk_data,
    input  logic                    lk_err,
    output logic                    busy,
    output logic                    done
);
    localparam int LA = 8 * ADDR_BYTES;

    seq_e          st;
    chan_e         ch;
    logic          pend;
    logic [1:0]    idx;
    logic          rsp_err;
    logic [7:0]    rsp_data;
    logic          done_q;

    logic          bus_go;
    logic          bus_wr;
    logic          bus_ack;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata;
    logic [7:0]    pkt_byte;
    logic          pkt_last;
    logic          cap_full;
    logic [LA-1:0] cap_addr;
    logic          rx_empty;
    logic          rx_push;
    logic          tx_free_sel;
    logic          unused_rd;

    assign rx_empty    = bus_rdata[EMPTY_BIT];
    assign rx_push     = (st == S_DRAIN) && bus_ack && !rx_empty;
    assign tx_free_sel = (ch == CH_NP) ? np_tx_free : pc_tx_free;
    assign unused_rd   = ^bus_rdata[DW-1:EMPTY_BIT+1];

    // A new bus command whenever a bus state has nothing outstanding.
    assign bus_go = !pend && (st == S_DRAIN || st == S_TXBYTE || st == S_COMMIT);
    assign bus_wr = (st != S_DRAIN);

    // Command address and data for the current step.
    always_comb begin
        bus_addr  = '0;
        bus_wdata = '0;
        case (st)
            S_DRAIN:  bus_addr = (ch == CH_NP) ? NP_RX_OFS : PC_RX_OFS;
            S_TXBYTE: begin
                bus_addr  = (ch == CH_NP) ? NP_TX_OFS : PC_TX_OFS;
                bus_wdata = {{(DW-8){1'b0}}, pkt_byte};
            end
            S_COMMIT: begin
                bus_addr  = CTL_OFS;
                bus_wdata = {{(DW-8){1'b0}}, (ch == CH_NP) ? NP_AVAIL : PC_AVAIL};
            end
            default: ;
        endcase
    end

    // Sequencer: channel pick, drain, lookup, packet, commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= S_IDLE;
            ch       <= CH_PC;
            pend     <= 1'b0;
            idx      <= '0;
            rsp_err  <= 1'b0;
            rsp_data <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (bus_go)  pend <= 1'b1;
            if (bus_ack) pend <= 1'b0;
            case (st)
                S_IDLE: begin
                    if (pc_req) begin
                        ch <= CH_PC;
                        st <= S_DRAIN;
                    end else if (np_req) begin
                        ch <= CH_NP;
                        st <= S_DRAIN;
                    end
                end
                S_DRAIN: if (bus_ack && rx_empty) st <= cap_full ? S_LOOKUP : S_IDLE;
                S_LOOKUP: if (lk_ready) begin
                    rsp_err  <= lk_err;
                    rsp_data <= lk_data;
                    st       <= S_TXWAIT;
                end
                S_TXWAIT: if (tx_free_sel) begin
                    idx <= '0;
                    st  <= S_TXBYTE;
                end
                S_TXBYTE: if (bus_ack) begin
                    if (pkt_last) st <= S_COMMIT;
                    else          idx <= idx + 1'b1;
                end
                S_COMMIT: if (bus_ack) begin
                    st     <= S_IDLE;
                    done_q <= 1'b1;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign lk_valid = (st == S_LOOKUP);
    assign lk_addr  = cap_addr;
    assign busy     = (st != S_IDLE);
    assign done     = done_q;

    rsp_bus_master #(.AW(AW), .DW(DW)) u_bus (
        .clk               (clk),
        .rst_n             (rst_n),
        .go                (bus_go),
        .go_wr             (bus_wr),
        .go_addr           (bus_addr),
        .go_data           (bus_wdata),
        .ack               (bus_ack),
        .rdata             (bus_rdata),
        .avm_address       (avm_address),
        .avm_read          (avm_read),
        .avm_write         (avm_write),
        .avm_writedata     (avm_writedata),
        .avm_readdata      (avm_readdata),
        .avm_readdatavalid (avm_readdatavalid),
        .avm_waitrequest   (avm_waitrequest)
    );

    rsp_pkt_gen #(.CT_OK(CT_OK), .CT_FAIL(CT_FAIL)) u_pkt (
        .idx      (idx),
        .err      (rsp_err),
        .data     (rsp_data),
        .pkt_byte (pkt_byte),
        .last     (pkt_last)
    );

    rsp_addr_cap #(.SKIP(HDR_SKIP), .ABYTES(ADDR_BYTES)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (st == S_IDLE),
        .push    (rx_push),
        .byte_in (bus_rdata[7:0]),
        .addr    (cap_addr),
        .full    (cap_full)
    );
endmodule

// File: rtl/rsp_pc_responder_chk.sv
// Port-level protocol checks for the completion responder, attached by bind.
// Assumes: default offsets of the responder.
module rsp_pc_responder_chk #(
    parameter int            AW        = 8,
    parameter int            DW        = 32,
    parameter int            LA        = 32,
    parameter logic [AW-1:0] PC_TX_OFS = 'h0C,
    parameter logic [AW-1:0] NP_TX_OFS = 'h14,
    parameter logic [AW-1:0] CTL_OFS   = 'h04
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pc_tx_free,
    input logic          np_tx_free,
    input logic [AW-1:0] avm_address,
    input logic          avm_read,
    input logic          avm_write,
    input logic [DW-1:0] avm_writedata,
    input logic          avm_waitrequest,
    input logic          lk_valid,
    input logic [LA-1:0] lk_addr,
    input logic          lk_ready,
    input logic          busy,
    input logic          done
);
    // R2
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        avm_read && avm_waitrequest |=> avm_read && $stable(avm_address));
    // R2
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        avm_write && avm_waitrequest |=> avm_write && $stable(avm_address) && $stable(avm_writedata));
    // R2
    rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(avm_read && avm_write));
    // R5
    lk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid && !lk_ready |=> lk_valid && $stable(lk_addr));
    // R10
    busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (avm_read || avm_write || lk_valid) |-> busy);
    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9
    pc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        avm_write && avm_address == PC_TX_OFS |-> pc_tx_free);
    // R9
    np_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        avm_write && avm_address == NP_TX_OFS |-> np_tx_free);
    // R8
    commit_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        avm_write && avm_address == CTL_OFS |-> (avm_writedata == 32'h1 || avm_writedata == 32'h2));
endmodule

bind rsp_pc_responder rsp_pc_responder_chk u_chk (.*);

// File: tb/tb_rsp_pc_responder.sv
// Bench: a behavioural register-slave and lookup model with expected-write
// and expected-lookup queues, checked on every clock.
module tb_rsp_pc_responder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pc_req = 1'b0, np_req = 1'b0;
    logic        pc_tx_free = 1'b1, np_tx_free = 1'b1;
    logic [7:0]  avm_address;
    logic        avm_read, avm_write;
    logic [31:0] avm_writedata;
    logic [31:0] avm_readdata = '0;
    logic        avm_readdatavalid = 1'b0;
    logic        avm_waitrequest = 1'b0;
    logic        lk_valid;
    logic [31:0] lk_addr;
    logic        lk_ready = 1'b0;
    logic [7:0]  lk_data;
    logic        lk_err;
    logic        busy, done;

    always #4 clk = ~clk;

    rsp_pc_responder dut (.*);

    function automatic logic fn_err(input logic [31:0] a);
        return a[31:28] == 4'hE;
    endfunction
    function automatic logic [7:0] fn_data(input logic [31:0] a);
        return a[7:0] ^ a[23:16] ^ 8'h5A;
    endfunction
    assign lk_data = fn_data(lk_addr);
    assign lk_err  = fn_err(lk_addr);

    int tests = 0, fails = 0;
    int done_cnt = 0, wr_cnt = 0, lk_cnt = 0;
    logic [7:0]  pcq[$], npq[$];
    logic [39:0] expw[$];
    string       expr[$];
    logic [31:0] expl[$];
    logic [15:0] lfsr = 16'hACE1;
    bit          mode_wait = 0;
    bit          rd_pend = 0, rd_np = 0, exp_done = 0, model_busy = 0;
    int          rd_dly = 0, rx_cnt = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Slave model and per-clock comparison.
    always @(negedge clk) begin
        if (!rst_n) begin
            avm_waitrequest = 0; avm_readdatavalid = 0; lk_ready = 0;
            rd_pend = 0; exp_done = 0; model_busy = 0;
        end else begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (exp_done || done) begin
                chk(done === exp_done, "R10", "done pulse", done, exp_done);
                chk(!busy, "R10", "busy with done", busy, 0);
            end
            if (done) done_cnt++;
            exp_done = 0;
            if (model_busy && !busy) chk(0, "R10", "busy dropped early", busy, 1);
            // read data return
            avm_readdatavalid = 0;
            if (rd_pend) begin
                if (rd_dly == 0) begin
                    avm_readdatavalid = 1;
                    rd_pend = 0;
                    if (rd_np ? npq.size() != 0 : pcq.size() != 0) begin
                        avm_readdata = {24'h0, rd_np ? npq.pop_front() : pcq.pop_front()};
                        rx_cnt++;
                    end else begin
                        avm_readdata = 32'h100;
                        if (rx_cnt < 7) model_busy = 0;
                    end
                end else rd_dly--;
            end
            avm_waitrequest = mode_wait ? (lfsr[0] & lfsr[5]) : 1'b0;
            lk_ready = mode_wait ? lfsr[2] : 1'b1;
            if (avm_read && !avm_waitrequest) begin
                chk(avm_address == 8'h08 || avm_address == 8'h10, "R3", "read offset", avm_address, 8'h08);
                if (!model_busy) begin model_busy = 1; rx_cnt = 0; end
                rd_pend = 1;
                rd_np = (avm_address == 8'h10);
                rd_dly = mode_wait ? int'(lfsr[4:3]) : 0;
            end
            if (avm_write && !avm_waitrequest) begin
                wr_cnt++;
                if (avm_address == 8'h0C && !pc_tx_free) chk(0, "R9", "pc write while busy", 1, 0);
                if (avm_address == 8'h14 && !np_tx_free) chk(0, "R9", "np write while busy", 1, 0);
                if (expw.size() == 0) chk(0, "R12", "unexpected write", {avm_address, avm_writedata}, 0);
                else begin
                    logic [39:0] e;
                    string r;
                    e = expw.pop_front();
                    r = expr.pop_front();
                    chk({avm_address, avm_writedata} == e, r, "write", {avm_address, avm_writedata}, e);
                end
                if (avm_address == 8'h04) begin exp_done = 1; model_busy = 0; end
            end
            if (lk_valid && lk_ready) begin
                lk_cnt++;
                if (expl.size() == 0) chk(0, "R12", "unexpected lookup", lk_addr, 0);
                else begin
                    logic [31:0] ea;
                    ea = expl.pop_front();
                    chk(lk_addr == ea, "R4", "lookup address", lk_addr, ea);
                end
            end
            pc_req = (pcq.size() != 0);
            np_req = (npq.size() != 0);
        end
    end

    task automatic push_req(input bit np, input logic [31:0] a, input int extra);
        logic [7:0] b[$];
        logic [7:0] tx;
        b = '{8'h06, 8'h00, 8'h01, a[31:24], a[23:16], a[15:8], a[7:0]};
        for (int i = 0; i < extra; i++) b.push_back(8'hC0 + 8'(i));
        tx = np ? 8'h14 : 8'h0C;
        expl.push_back(a);
        if (fn_err(a)) begin
            expw.push_back({tx, 32'h0C}); expr.push_back("R7");
            expw.push_back({tx, 32'h00}); expr.push_back("R7");
            expw.push_back({tx, 32'h00}); expr.push_back("R7");
        end else begin
            expw.push_back({tx, 32'h0F}); expr.push_back("R6");
            expw.push_back({tx, 32'h00}); expr.push_back("R6");
            expw.push_back({tx, 32'h01}); expr.push_back("R6");
            expw.push_back({tx, 24'h0, fn_data(a)}); expr.push_back("R6");
        end
        expw.push_back({8'h04, np ? 32'h2 : 32'h1}); expr.push_back("R8");
        foreach (b[i]) begin
            if (np) npq.push_back(b[i]); else pcq.push_back(b[i]);
        end
    endtask

    task automatic wait_done(input int target, input string req);
        for (int i = 0; i < 3000 && done_cnt < target; i++) @(posedge clk);
        chk(done_cnt >= target, req, "completion count", done_cnt, target);
        chk(expw.size() == 0, req, "writes left", expw.size(), 0);
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL R10 watchdog expired: actual hung expected finish");
        summary();
        $finish;
    end

    initial begin
        int d0, w0, l0;
        repeat (3) @(negedge clk);
        // R1 during reset
        chk({busy, done, avm_read, avm_write, lk_valid} == 0, "R1", "outputs in reset",
            {busy, done, avm_read, avm_write, lk_valid}, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        chk({busy, done, avm_read, avm_write, lk_valid} == 0, "R1", "outputs after reset",
            {busy, done, avm_read, avm_write, lk_valid}, 0);
        // R6 R8 clean peripheral request
        @(posedge clk); #1 push_req(0, 32'h1234_5678, 0);
        wait_done(1, "R6");
        // R2 R3 non-posted under stalls
        @(posedge clk); #1 mode_wait = 1; push_req(1, 32'hA0B1_C2D3, 0);
        wait_done(2, "R2");
        // R7 error completion
        @(posedge clk); #1 push_req(0, 32'hE000_0042, 0);
        wait_done(3, "R7");
        // R4 trailing bytes ignored
        @(posedge clk); #1 push_req(1, 32'h0F0E_0D0C, 3);
        wait_done(4, "R4");
        // R9 transmit FIFO held busy
        @(posedge clk); #1 pc_tx_free = 0; w0 = wr_cnt; push_req(0, 32'h5555_AAAA, 0);
        repeat (80) @(posedge clk);
        chk(wr_cnt == w0, "R9", "writes while not free", wr_cnt, w0);
        chk(expl.size() == 0, "R9", "lookup finished", expl.size(), 0);
        chk(busy, "R10", "busy while waiting", busy, 1);
        #1 pc_tx_free = 1;
        wait_done(5, "R9");
        // R11 both pending, peripheral first
        @(posedge clk); #1 mode_wait = 0;
        push_req(0, 32'h0000_0011, 0); push_req(1, 32'h0000_0022, 0);
        begin
            logic [39:0] t[$]; string tr[$];
            t = expw; tr = expr;
            expw = '{t[0], t[1], t[2], t[3], t[4], t[5], t[6], t[7], t[8], t[9]};
            for (int i = 0; i < 10; i++) tr[i] = "R11";
            expr = tr;
        end
        wait_done(7, "R11");
        // R12 truncated request
        @(posedge clk); #1 d0 = done_cnt; w0 = wr_cnt; l0 = lk_cnt;
        pcq.push_back(8'h06); pcq.push_back(8'h00);
        repeat (40) @(posedge clk);
        @(negedge clk);
        chk(done_cnt == d0, "R12", "done after abort", done_cnt, d0);
        chk(wr_cnt == w0, "R12", "writes after abort", wr_cnt, w0);
        chk(lk_cnt == l0, "R12", "lookup after abort", lk_cnt, l0);
        chk(!busy, "R12", "idle after abort", busy, 0);
        summary();
        $finish;
    end
endmodule